// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides one unsigned W-bit integer by another over several clock cycles. A one-cycle start strobe, taken only while the block is idle, captures the dividend and the divisor. The block then handles one quotient bit per cycle. Each cycle it shifts the remainder and quotient pair left by one bit. It then adds the divisor to the remainder or subtracts it, and the sign of the remainder before the shift decides which. A failed subtraction is never undone in the same step. After the last bit, one correction cycle adds the divisor back if the remainder came out negative.

The design is meant to sit beside a control unit that has no fixed-latency divide path. The caller raises `start` for one cycle and waits for the single-cycle `done` pulse. It then reads `quotient`, `remainder` and `div_zero`, which hold their values until the next accepted start. `busy` high means the block is working, and any start seen then is dropped, so `!busy` serves as the ready signal for a request. A zero divisor skips the iteration loop entirely.

Top module: `nr_divider`

## Requirements
- R1: After reset, `busy` and `done` are 0.
- R2: For a nonzero divisor D and dividend X, the outputs at `done` satisfy X = quotient*D + remainder with remainder < D, all values unsigned.
- R3: For a nonzero divisor, `done` is high in the (W+2)-th cycle after the clock edge that accepts the start: W shift-and-add cycles, one correction cycle, then the done cycle.
- R4: `done` is high for exactly one cycle and `busy` is 0 while it is high. `quotient` and `remainder` keep their values from `done` until the next accepted start.
- R5: A zero divisor sets `div_zero` to 1, makes `quotient` all ones and makes `remainder` equal to the dividend. `done` follows in the 2nd cycle after the accepting edge.
- R6: A start with a nonzero divisor clears `div_zero` to 0.
- R7: A start raised while `busy` is 1 is ignored. The running operation finishes with the operands it captured.
- R8: `busy` is 1 in the cycle after an accepted start and stays 1 until the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, accepted only while busy is 0 |
| dividend | input | W | Unsigned dividend, captured on an accepted start |
| divisor | input | W | Unsigned divisor, captured on an accepted start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Unsigned quotient |
| remainder | output | W | Unsigned remainder |
| div_zero | output | 1 | Last operation had a zero divisor |

## Verification
At W=4 the bench runs every dividend and divisor pair, so every sign sequence the remainder register can take is tried at least once. That sweep includes the pairs that need the final correction and the pairs that do not, which tells a wrong add-back apart from a wrong add/subtract choice. At W=8 it runs fixed corners (largest over one, equal operands, small over large, zero dividend) and a pseudo-random batch, which exposes shift and carry faults at the top bit that a 4-bit width cannot show. Separate sequences cover zero-divisor results, clearing of the flag, a start dropped while busy, and results held after `done`.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2
  } nrdiv_state_e;
endpackage

// File: rtl/nrdiv_addsub.sv
module nrdiv_addsub #(
  parameter int AW = 9
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  input  logic          sub,
  output logic [AW-1:0] y
);
  logic [AW-1:0] b_eff;
  always_comb begin
    b_eff = b ^ {AW{sub}};
    y     = a + b_eff + {{(AW-1){1'b0}}, sub};
  end
endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
  import nrdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic zero_div,
  output logic load,
  output logic iter,
  output logic fix,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] NSTEP = CW'(W);

  nrdiv_state_e state;
  logic [CW-1:0] steps_left;

  always_comb begin
    busy = (state != ST_IDLE);
    load = start && (state == ST_IDLE);
    iter = (state == ST_ITER);
    fix  = (state == ST_FIX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      steps_left <= '0;
      done       <= 1'b0;
    end else begin
      done <= fix;
      case (state)
        ST_IDLE: if (start) begin
          steps_left <= NSTEP;
          state      <= zero_div ? ST_FIX : ST_ITER;
        end
        ST_ITER: begin
          steps_left <= steps_left - 1'b1;
          if (steps_left == CW'(1)) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nr_divider.sv
module nr_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_zero
);
  localparam int AW = W + 1;

  logic          load, iter, fix, zero_in;
  logic [AW-1:0] a_q;
  logic [W-1:0]  q_q, d_q;
  logic          dz_q;
  logic [AW-1:0] shifted, opnd, sum;
  logic          do_sub;

  assign zero_in = (divisor == '0);

  nrdiv_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .zero_div(zero_in),
    .load(load), .iter(iter), .fix(fix), .busy(busy), .done(done)
  );

  always_comb begin
    shifted = {a_q[W-1:0], q_q[W-1]};
    opnd    = iter ? shifted : a_q;
    do_sub  = iter && !a_q[W];
  end

  nrdiv_addsub #(.AW(AW)) u_addsub (
    .a(opnd), .b({1'b0, d_q}), .sub(do_sub), .y(sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      q_q  <= '0;
      d_q  <= '0;
      dz_q <= 1'b0;
    end else if (load) begin
      a_q  <= zero_in ? {1'b0, dividend} : '0;
      q_q  <= zero_in ? '1 : dividend;
      d_q  <= divisor;
      dz_q <= zero_in;
    end else if (iter) begin
      a_q <= sum;
      q_q <= {q_q[W-2:0], ~sum[W]};
    end else if (fix && a_q[W]) begin
      a_q <= sum;
    end
  end

  assign quotient  = q_q;
  assign remainder = a_q[W-1:0];
  assign div_zero  = dz_q;
endmodule

// File: rtl/nrdiv_chk.sv
module nrdiv_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         div_zero,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic [W-1:0] dsr
);
  logic [15:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (start && !busy) cyc <= 16'd1;
    else if (cyc != 16'hFFFF) cyc <= cyc + 16'd1;
  end

  // R4
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R4
  hold_quot_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> $stable(quotient));
  // R4
  hold_rem_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !done) |-> $stable(remainder));
  // R2
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && !div_zero) |-> (remainder < dsr));
  // R3
  lat_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && !div_zero) |-> (cyc == 16'(W + 2)));
  // R5
  zero_lat_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && div_zero) |-> (cyc == 16'd2));
  // R5
  zero_quot_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && div_zero) |-> (quotient == '1));
  // R8
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
endmodule

bind nr_divider nrdiv_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .div_zero(div_zero), .quotient(quotient), .remainder(remainder), .dsr(d_q)
);

// File: tb/sim_nr_divider.sv
module sim_nr_divider;
  localparam int CLK_PERIOD = 10;
  localparam int WA = 4;
  localparam int WB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          s4 = 1'b0, s8 = 1'b0;
  logic [WA-1:0] x4 = '0, d4 = '0, q4, r4;
  logic [WB-1:0] x8 = '0, d8 = '0, q8, r8;
  logic          b4, dn4, z4, b8, dn8, z8;

  nr_divider #(.W(WA)) u0 (
    .clk(clk), .rst_n(rst_n), .start(s4), .dividend(x4), .divisor(d4),
    .busy(b4), .done(dn4), .quotient(q4), .remainder(r4), .div_zero(z4)
  );
  nr_divider #(.W(WB)) u1 (
    .clk(clk), .rst_n(rst_n), .start(s8), .dividend(x8), .divisor(d8),
    .busy(b8), .done(dn8), .quotient(q8), .remainder(r8), .div_zero(z8)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run4(input int x, input int d);
    int cyc;
    @(negedge clk);
    x4 = WA'(x); d4 = WA'(d); s4 = 1'b1;
    @(negedge clk);
    s4 = 1'b0; cyc = 1;
    check(b4 == 1'b1, "R8 busy after accept", b4, 1);
    while (!dn4 && cyc < 100) begin @(negedge clk); cyc++; end
    check(b4 == 1'b0, "R4 busy low at done", b4, 0);
    if (d == 0) begin
      check(cyc == 2, "R5 zero latency", cyc, 2);
      check(z4 == 1'b1, "R5 zero flag", z4, 1);
      check(q4 == '1, "R5 zero quotient", q4, (1 << WA) - 1);
      check(r4 == WA'(x), "R5 zero remainder", r4, x);
    end else begin
      check(cyc == WA + 2, "R3 latency W=4", cyc, WA + 2);
      check(z4 == 1'b0, "R6 flag clear", z4, 0);
      check(q4 == WA'(x / d), "R2 quotient W=4", q4, x / d);
      check(r4 == WA'(x % d), "R2 remainder W=4", r4, x % d);
    end
    @(negedge clk);
    check(dn4 == 1'b0, "R4 done single cycle", dn4, 0);
  endtask

  task automatic run8(input int x, input int d);
    int cyc;
    @(negedge clk);
    x8 = WB'(x); d8 = WB'(d); s8 = 1'b1;
    @(negedge clk);
    s8 = 1'b0; cyc = 1;
    while (!dn8 && cyc < 100) begin @(negedge clk); cyc++; end
    if (d == 0) begin
      check(cyc == 2, "R5 zero latency W=8", cyc, 2);
      check(z8 == 1'b1 && q8 == '1 && r8 == WB'(x), "R5 zero result W=8", r8, x);
    end else begin
      check(cyc == WB + 2, "R3 latency W=8", cyc, WB + 2);
      check(z8 == 1'b0, "R6 flag clear W=8", z8, 0);
      check(q8 == WB'(x / d), "R2 quotient W=8", q8, x / d);
      check(r8 == WB'(x % d), "R2 remainder W=8", r8, x % d);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(b4 == 1'b0 && dn4 == 1'b0, "R1 reset state", {b4, dn4}, 0);
    check(b8 == 1'b0 && dn8 == 1'b0, "R1 reset state W=8", {b8, dn8}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R5 R6: every pair at W=4
    for (int x = 0; x < (1 << WA); x++)
      for (int d = 0; d < (1 << WA); d++)
        run4(x, d);

    // R2: corners at W=8
    run8(255, 1);
    run8(255, 255);
    run8(1, 255);
    run8(0, 5);
    run8(128, 3);
    run8(77, 0);
    run8(200, 13);   // R6: clears flag after zero divisor
    for (int i = 0; i < 1500; i++) run8(int'($urandom % 256), int'($urandom % 256));

    // R7: start while busy is ignored
    @(negedge clk);
    x8 = 8'd200; d8 = 8'd7; s8 = 1'b1;
    @(negedge clk);
    x8 = 8'd9; d8 = 8'd2;
    @(negedge clk);
    s8 = 1'b0;
    while (!dn8) @(negedge clk);
    check(q8 == 8'd28, "R7 ignored start quotient", q8, 28);
    check(r8 == 8'd4, "R7 ignored start remainder", r8, 4);

    // R4: results held after done
    repeat (4) @(negedge clk);
    check(q8 == 8'd28 && r8 == 8'd4, "R4 results held", r8, 4);
    check(b8 == 1'b0 && dn8 == 1'b0, "R4 idle after done", {b8, dn8}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule